// File: doc/BRIEF.md
# Lane Symbol Aligner and Decoder

This block sits behind a deserializer that hands over one 10-bit word per word clock from a single serial video lane. The deserializer has no idea where symbols begin, so each word straddles two symbols at some fixed but unknown bit offset. The block finds that offset by looking for blanking control codewords, slides a 10-bit window to the offset it finds, and decodes each aligned symbol. The result is either a pixel byte marked with a data-enable or a pair of control bits.

While searching, the block tests one offset at a time. It stays on the current offset for as long as control codewords keep turning up there. If none appear for a timeout period, it moves to the next offset. Once a run of consecutive control codewords has been seen, it declares lock. While locked, it counts symbols that are neither a control codeword nor a self-consistent data symbol. If too many such symbols arrive within one frame, lock is dropped and the search resumes from the offset in use.

Top module: `tmds_lane_rx`

## Requirements
- R1: While reset is asserted, and right after it is released, `locked_o`, `de_o`, `data_o` and `ctrl_o` are all zero.
- R2: Four 10-bit values, written bit 9 down to bit 0, are control codewords. 0x354 carries control bits 00, 0x0AB carries 01, 0x154 carries 10 and 0x2AB carries 11. On lane 0, `ctrl_o[0]` is horizontal sync and `ctrl_o[1]` is vertical sync. While locked, a control codeword yields `ctrl_o` equal to its bits with `de_o` at 0.
- R3: Any other symbol is decoded as data in two steps. First, when bit 9 is 1, bits 7..0 are inverted. Second, from these bits q, the byte is d[0]=q[0] and d[i]=q[i]^q[i-1] when bit 8 is 1, or the inverse of that XOR when bit 8 is 0. While locked, a plausible data symbol gives `de_o`=1 and `data_o`=d.
- R4: Word bit 0 is the earliest bit on the line. The symbol seen at offset o is bits o..o+9 of the 20-bit value {current word, previous word}, so every offset 0..9 can be locked.
- R5: Lock is declared when LOCK_RUN (8) consecutive symbols at the current offset are control codewords. Any other symbol restarts the run.
- R6: The offset is 0 after reset. While unlocked, if TIMEOUT (64) consecutive symbols pass with no control codeword, the offset advances by one, and 9 wraps to 0.
- R7: A data symbol is implausible when bit 8 disagrees with the byte it decodes to. Bit 8 must be 0 exactly when the byte has more than four ones, or exactly four ones with bit 0 clear. While locked, an implausible non-control symbol gives `de_o`=0 and `ctrl_o`=0. The (ERR_LIMIT+1)-th such symbol within a frame drops lock, with ERR_LIMIT = 4. The count restarts when a control codeword with vertical sync 1 follows one with vertical sync 0.
- R8: The outputs for a symbol appear one clock after the edge that takes in the word completing it. They are judged against the lock state held before that edge, and they are all zero while unlocked.
- R9: After lock is lost, the search resumes at the same offset. It relocks after LOCK_RUN control codewords, with no offset change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one 10-bit word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 10 | Raw word from the deserializer, bit 0 earliest |
| locked_o | output | 1 | Symbol boundary found |
| de_o | output | 1 | `data_o` holds a decoded pixel byte |
| data_o | output | 8 | Decoded byte |
| ctrl_o | output | 2 | Decoded control bits (bit 0 hsync, bit 1 vsync on lane 0) |

## Verification
The lock state and the output register change on the same edge in two places. The first is the symbol that completes the control run. The second is the implausible symbol that pushes the per-frame error count past its limit. The bench provokes both directly. It sends exactly seven and then eight controls after a broken run, and it sends exactly ERR_LIMIT and then one more bad symbol, in one case across a vertical sync rise. The completing or offending symbol must itself produce no output, `locked_o` must change on that same edge, and the following symbol is judged under the new lock state.

// File: rtl/tmds_lane_rx_pkg.sv
package tmds_lane_rx_pkg;

  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int OFFS_W = $clog2(SYM_W);
  localparam int CTL_N  = 4;

  typedef enum logic [1:0] {
    SYM_CTRL = 2'd0,
    SYM_DATA = 2'd1,
    SYM_BAD  = 2'd2
  } sym_cls_e;

  typedef struct packed {
    sym_cls_e            cls;
    logic [BYTE_W-1:0]   byte_val;
    logic [1:0]          ctl;
  } sym_dec_t;

  // Control codeword for a given pair of control bits.
  function automatic logic [SYM_W-1:0] ctl_code(input logic [1:0] c);
    logic [SYM_W-1:0] r;
    case (c)
      2'b00:   r = 10'h354;
      2'b01:   r = 10'h0AB;
      2'b10:   r = 10'h154;
      default: r = 10'h2AB;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmds_sym_window.sv
module tmds_sym_window
  import tmds_lane_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SYM_W-1:0]  word_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [SYM_W-1:0]  sym_o
);

  localparam int PAIR_W = 2 * SYM_W - 1;

  logic [SYM_W-1:0]  prev_q;
  logic [SYM_W-1:0]  prev_d;
  logic [PAIR_W-1:0] pair;
  logic [SYM_W-1:0]  cand [SYM_W];

  assign prev_d = word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  // Top bit of the current word is never inside any window.
  assign pair = {word_i[SYM_W-2:0], prev_q};

  for (genvar k = 0; k < SYM_W; k++) begin : g_rot
    assign cand[k] = pair[k +: SYM_W];
  end

  always_comb begin
    sym_o = cand[0];
    for (int k = 1; k < SYM_W; k++) begin
      if (offs_i == OFFS_W'(k)) begin
        sym_o = cand[k];
      end
    end
  end

endmodule

// File: rtl/tmds_sym_decode.sv
module tmds_sym_decode
  import tmds_lane_rx_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output sym_dec_t         dec_o
);

  localparam int ONES_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] chained;
  logic [BYTE_W-1:0] plain;
  logic [ONES_W-1:0] ones;
  logic              use_xor;
  logic              want_xor;
  logic              ctl_hit;
  logic [1:0]        ctl_val;

  // Undo the conditional inversion.
  assign chained = sym_i[SYM_W-1] ? ~sym_i[BYTE_W-1:0] : sym_i[BYTE_W-1:0];
  assign use_xor = sym_i[BYTE_W];

  // Undo the XOR / XNOR chaining.
  always_comb begin
    plain[0] = chained[0];
    for (int i = 1; i < BYTE_W; i++) begin
      plain[i] = use_xor ? (chained[i] ^ chained[i-1])
                         : ~(chained[i] ^ chained[i-1]);
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ones = ones + ONES_W'(plain[i]);
    end
  end

  // The chaining choice an encoder would have made for this byte.
  assign want_xor = !((ones > ONES_W'(BYTE_W / 2)) ||
                      ((ones == ONES_W'(BYTE_W / 2)) && !plain[0]));

  always_comb begin
    ctl_hit = 1'b0;
    ctl_val = 2'b00;
    for (int c = 0; c < CTL_N; c++) begin
      if (sym_i == ctl_code(2'(c))) begin
        ctl_hit = 1'b1;
        ctl_val = 2'(c);
      end
    end
  end

  always_comb begin
    dec_o.byte_val = '0;
    dec_o.ctl      = '0;
    if (ctl_hit) begin
      dec_o.cls = SYM_CTRL;
      dec_o.ctl = ctl_val;
    end else if (want_xor == use_xor) begin
      dec_o.cls      = SYM_DATA;
      dec_o.byte_val = plain;
    end else begin
      dec_o.cls = SYM_BAD;
    end
  end

endmodule

// File: rtl/tmds_align_ctrl.sv
module tmds_align_ctrl
  import tmds_lane_rx_pkg::*;
#(
  parameter int LOCK_RUN  = 8,
  parameter int TIMEOUT   = 64,
  parameter int ERR_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_ctrl_i,
  input  logic              is_bad_i,
  input  logic              vsync_i,
  output logic [OFFS_W-1:0] offs_o,
  output logic              lock_o
);

  localparam int RUN_W = (LOCK_RUN  > 1) ? $clog2(LOCK_RUN)      : 1;
  localparam int TO_W  = (TIMEOUT   > 1) ? $clog2(TIMEOUT)       : 1;
  localparam int ERR_W = $clog2(ERR_LIMIT + 2);

  logic [OFFS_W-1:0] offs_q, offs_d;
  logic              lock_q, lock_d;
  logic [RUN_W-1:0]  run_q,  run_d;
  logic [TO_W-1:0]   to_q,   to_d;
  logic [ERR_W-1:0]  err_q,  err_d;
  logic              vs_q,   vs_d;
  logic              frame_start;

  assign frame_start = is_ctrl_i && vsync_i && !vs_q;

  always_comb begin
    offs_d = offs_q;
    lock_d = lock_q;
    run_d  = run_q;
    to_d   = to_q;
    err_d  = err_q;
    vs_d   = is_ctrl_i ? vsync_i : vs_q;

    if (!lock_q) begin
      err_d = '0;
      if (is_ctrl_i) begin
        to_d = '0;
        if (run_q == RUN_W'(LOCK_RUN - 1)) begin
          lock_d = 1'b1;
          run_d  = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
        if (to_q == TO_W'(TIMEOUT - 1)) begin
          to_d   = '0;
          offs_d = (offs_q == OFFS_W'(SYM_W - 1)) ? '0 : offs_q + 1'b1;
        end else begin
          to_d = to_q + 1'b1;
        end
      end
    end else begin
      if (frame_start) begin
        err_d = '0;
      end else if (is_bad_i) begin
        if (err_q == ERR_W'(ERR_LIMIT)) begin
          lock_d = 1'b0;
          err_d  = '0;
          run_d  = '0;
          to_d   = '0;
        end else begin
          err_d = err_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
      lock_q <= 1'b0;
      run_q  <= '0;
      to_q   <= '0;
      err_q  <= '0;
      vs_q   <= 1'b0;
    end else begin
      offs_q <= offs_d;
      lock_q <= lock_d;
      run_q  <= run_d;
      to_q   <= to_d;
      err_q  <= err_d;
      vs_q   <= vs_d;
    end
  end

  assign offs_o = offs_q;
  assign lock_o = lock_q;

endmodule

// File: rtl/tmds_lane_rx.sv
module tmds_lane_rx
  import tmds_lane_rx_pkg::*;
#(
  parameter int LOCK_RUN  = 8,
  parameter int TIMEOUT   = 64,
  parameter int ERR_LIMIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  word_i,
  output logic        locked_o,
  output logic        de_o,
  output logic [7:0]  data_o,
  output logic [1:0]  ctrl_o
);

  logic [SYM_W-1:0]  sym_w;
  sym_dec_t          dec_w;
  logic [OFFS_W-1:0] offs_w;
  logic              lock_w;
  logic              sym_is_ctrl;
  logic              sym_is_bad;

  logic              de_q,   de_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [1:0]        ctrl_q, ctrl_d;

  tmds_sym_window u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_i (word_i),
    .offs_i (offs_w),
    .sym_o  (sym_w)
  );

  tmds_sym_decode u_decode (
    .sym_i (sym_w),
    .dec_o (dec_w)
  );

  assign sym_is_ctrl = (dec_w.cls == SYM_CTRL);
  assign sym_is_bad  = (dec_w.cls == SYM_BAD);

  tmds_align_ctrl #(
    .LOCK_RUN  (LOCK_RUN),
    .TIMEOUT   (TIMEOUT),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_ctrl_i (sym_is_ctrl),
    .is_bad_i  (sym_is_bad),
    .vsync_i   (dec_w.ctl[1]),
    .offs_o    (offs_w),
    .lock_o    (lock_w)
  );

  always_comb begin
    de_d   = lock_w && (dec_w.cls == SYM_DATA);
    data_d = de_d ? dec_w.byte_val : '0;
    ctrl_d = (lock_w && sym_is_ctrl) ? dec_w.ctl : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q   <= 1'b0;
      data_q <= '0;
      ctrl_q <= 2'b00;
    end else begin
      de_q   <= de_d;
      data_q <= data_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign locked_o = lock_w;
  assign de_o     = de_q;
  assign data_o   = data_q;
  assign ctrl_o   = ctrl_q;

endmodule

// File: rtl/tmds_lane_rx_chk.sv
module tmds_lane_rx_chk
  import tmds_lane_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              locked_o,
  input logic              de_o,
  input logic [BYTE_W-1:0] data_o,
  input logic [1:0]        ctrl_o,
  input logic [OFFS_W-1:0] offs,
  input logic              sym_is_ctrl,
  input logic              sym_is_bad
);

  a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |=> (!de_o && ctrl_o == 2'b00 && data_o == '0));

  a_r2_de_excludes_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (ctrl_o == 2'b00));

  a_r6_offs_range: assert property (@(posedge clk) disable iff (!rst_n)
    offs <= OFFS_W'(SYM_W - 1));

  a_r6_offs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (offs != $past(offs)) |->
      (offs == (($past(offs) == OFFS_W'(SYM_W - 1)) ? '0 : $past(offs) + 1'b1)));

  a_r9_offs_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> $stable(offs));

  a_r5_lock_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(sym_is_ctrl));

  a_r7_drop_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(sym_is_bad));

endmodule

bind tmds_lane_rx tmds_lane_rx_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .locked_o    (locked_o),
  .de_o        (de_o),
  .data_o      (data_o),
  .ctrl_o      (ctrl_o),
  .offs        (offs_w),
  .sym_is_ctrl (sym_is_ctrl),
  .sym_is_bad  (sym_is_bad)
);

// File: tb/tmds_lane_rx_tb_top.sv
`timescale 1ns/1ps
module tmds_lane_rx_tb_top;

  localparam int TIMEOUT   = 64;
  localparam int LOCK_RUN  = 8;
  localparam int ERR_LIMIT = 4;
  localparam logic [9:0] C00 = 10'h354;
  localparam logic [9:0] C01 = 10'h0AB;
  localparam logic [9:0] C10 = 10'h154;
  localparam logic [9:0] C11 = 10'h2AB;
  localparam logic [9:0] BADSYM = 10'h155;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] word_i = '0;
  logic       locked_o;
  logic       de_o;
  logic [7:0] data_o;
  logic [1:0] ctrl_o;

  int n_chk = 0;
  int n_err = 0;
  int disp  = 0;
  bit done  = 1'b0;
  bit bq[$];

  always #2.5 clk = ~clk;

  tmds_lane_rx dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_i   (word_i),
    .locked_o (locked_o),
    .de_o     (de_o),
    .data_o   (data_o),
    .ctrl_o   (ctrl_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Reference encoder with running disparity, written from the coding rules.
  function automatic logic [9:0] enc(input logic [7:0] d);
    logic [8:0] qm;
    logic [9:0] q;
    int n1, n1q, n0q;
    n1 = $countones(d);
    qm[0] = d[0];
    if (n1 > 4 || (n1 == 4 && d[0] == 1'b0)) begin
      for (int i = 1; i < 8; i++) qm[i] = ~(qm[i-1] ^ d[i]);
      qm[8] = 1'b0;
    end else begin
      for (int i = 1; i < 8; i++) qm[i] = qm[i-1] ^ d[i];
      qm[8] = 1'b1;
    end
    n1q = $countones(qm[7:0]);
    n0q = 8 - n1q;
    if (disp == 0 || n1q == n0q) begin
      q = {~qm[8], qm[8], (qm[8] ? qm[7:0] : ~qm[7:0])};
      disp += qm[8] ? (n1q - n0q) : (n0q - n1q);
    end else if ((disp > 0 && n1q > n0q) || (disp < 0 && n0q > n1q)) begin
      q = {1'b1, qm[8], ~qm[7:0]};
      disp += 2 * int'(qm[8]) + (n0q - n1q);
    end else begin
      q = {1'b0, qm[8], qm[7:0]};
      disp += -2 * int'(!qm[8]) + (n1q - n0q);
    end
    return q;
  endfunction

  function automatic logic [7:0] pat(input int i);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    return 8'((i * 73 + 5) & 255);
  endfunction

  // Push one symbol into the serial stream; clock out every full word.
  task automatic send(input logic [9:0] s);
    for (int j = 0; j < 10; j++) bq.push_back(s[j]);
    while (bq.size() >= 10) begin
      logic [9:0] w;
      for (int j = 0; j < 10; j++) w[j] = bq.pop_front();
      @(negedge clk);
      word_i = w;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic slip(input int k);
    for (int j = 0; j < k; j++) bq.push_back(1'b0);
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    #1;
    chk(locked_o == 0 && de_o == 0 && data_o == 0 && ctrl_o == 0, "R1 in reset",
        {locked_o, de_o, data_o, ctrl_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(locked_o == 0 && de_o == 0 && data_o == 0 && ctrl_o == 0, "R1 after release",
        {locked_o, de_o, data_o, ctrl_o}, 0);
  endtask

  // Blanking until locked; R6 search across offsets, R8 quiet while unlocked.
  task automatic t_acquire(input int bound, input string req);
    int n = 0;
    bit quiet = 1'b1;
    while (!locked_o && n < bound) begin
      send(C00);
      n++;
      if (!locked_o && (de_o || ctrl_o != 0 || data_o != 0)) quiet = 1'b0;
    end
    chk(locked_o == 1, req, locked_o, 1);
    chk(quiet, "R8 outputs zero while unlocked", quiet, 1);
  endtask

  // R3 R4 R8: data bytes come out one send later.
  task automatic t_data(input string req);
    logic [7:0] last;
    last = pat(0);
    send(enc(last));
    for (int i = 1; i < 16; i++) begin
      logic [7:0] b;
      b = pat(i);
      send(enc(b));
      chk(de_o == 1 && data_o == last && ctrl_o == 0, req, {de_o, data_o}, {1'b1, last});
      last = b;
    end
    send(C00);
    chk(de_o == 1 && data_o == last, req, {de_o, data_o}, {1'b1, last});
  endtask

  // R2: each control codeword maps to its control bits.
  task automatic t_ctrl();
    logic [9:0] codes [4];
    codes[0] = C01; codes[1] = C10; codes[2] = C11; codes[3] = C00;
    send(codes[0]);
    for (int i = 1; i < 4; i++) begin
      send(codes[i]);
      chk(de_o == 0 && ctrl_o == 2'(i == 1 ? 1 : (i == 2 ? 2 : 3)), "R2 control bits",
          {de_o, ctrl_o}, (i == 1 ? 1 : (i == 2 ? 2 : 3)));
    end
    send(C00);
    chk(de_o == 0 && ctrl_o == 2'b00, "R2 control bits 00", {de_o, ctrl_o}, 0);
  endtask

  // R7: limit errors tolerated, one more drops lock.
  task automatic t_errdrop();
    send(C00);
    for (int i = 0; i < ERR_LIMIT; i++) begin
      send(BADSYM);
      send(enc(8'h42));
      if (i == 0) chk(de_o == 0 && ctrl_o == 0, "R7 bad symbol output", {de_o, ctrl_o}, 0);
    end
    send(C00);
    chk(locked_o == 1, "R7 still locked at limit", locked_o, 1);
    send(BADSYM);
    send(C00);
    chk(locked_o == 0, "R7 lock dropped past limit", locked_o, 0);
  endtask

  // R5 R9: broken run does not lock; full run relocks at same offset.
  task automatic t_relock();
    repeat (4) send(C00);
    send(enc(8'h99));
    repeat (8) send(C00);
    chk(locked_o == 0, "R5 broken run not locked", locked_o, 0);
    send(C00);
    chk(locked_o == 1, "R5 R9 relock after run", locked_o, 1);
  endtask

  // R7: count restarts on vsync rise.
  task automatic t_frame();
    send(C00);
    for (int i = 0; i < ERR_LIMIT; i++) begin send(BADSYM); send(enc(8'h17)); end
    send(C00);
    send(C10);
    send(C00);
    for (int i = 0; i < ERR_LIMIT; i++) begin send(BADSYM); send(enc(8'h17)); end
    send(C00);
    chk(locked_o == 1, "R7 count restarted by frame", locked_o, 1);
    send(BADSYM);
    send(C00);
    chk(locked_o == 0, "R7 drop in new frame", locked_o, 0);
  endtask

  task automatic drop_lock();
    send(C00);
    for (int i = 0; i <= ERR_LIMIT; i++) begin send(BADSYM); send(C00); end
    chk(locked_o == 0, "R7 forced drop", locked_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    slip(3);
    t_reset();
    t_acquire(3 * TIMEOUT + LOCK_RUN + 24, "R4 R6 lock at offset 3");
    t_data("R3 R4 R8 data at offset 3");
    t_ctrl();
    t_errdrop();
    t_relock();
    t_data("R9 R3 data after relock");
    t_frame();
    t_relock();
    drop_lock();
    slip(6);
    t_acquire(7 * TIMEOUT + LOCK_RUN + 24, "R4 R6 lock at offset 9");
    t_data("R3 R4 data at offset 9");
    drop_lock();
    slip(3);
    t_acquire(4 * TIMEOUT + LOCK_RUN + 24, "R6 wrap lock at offset 2");
    t_data("R6 R3 data after wrap");
    report();
  end

endmodule